// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block drives a word-organised serial EEPROM over a chip-select, serial-clock and data-in/data-out bus. A system-side agent gives it one operation at a time on a small command port: read a word, write a word or erase a word. It answers with a single-cycle completion strobe, an error flag and, for reads, the returned word. The serial clock comes from a programmable divider of the system clock. Every bus frame opens with a start bit and sends its bits most-significant first.

Program operations are wrapped by the block itself. It sends an enable-programming frame first and the program frame next. It then drops chip-select for a configurable minimum gap and raises it again, with no clock, to watch the ready/busy level on the data-out line. When the device reports ready, or when a configurable number of busy samples has elapsed, it sends a disable-programming frame and reports completion. On reads, the filler zero that the device places ahead of the data is discarded.

Top module: `uw_eeprom_host`

## Requirements
- R1: While reset is held and in the first cycle after it, chip-select, serial clock, data-in, `cmd_busy`, `rsp_done` and `rsp_err` are all low.
- R2: Each frame is a 1 start bit, then a 2-bit wire code, then the address, then any write data, all most-significant first. The wire codes are read 10, write 01 and erase 11. Both programming-control frames use code 00; the enable frame puts 11 in the top two address bits and zeros below them, and the disable frame sends an all-zero address. Data-in changes only while the serial clock is low, and it is held low during the data pulses of a read.
- R3: During a frame, each high and each low level of the serial clock lasts `cfg_half_div`+1 system cycles. The serial clock is low whenever chip-select is low.
- R4: A read sends a frame of 3+ADDR_W+DATA_W clock pulses (25 by default). The bit returned just after the last address bit is discarded, and the next DATA_W bits, most-significant first, appear on `rsp_rdata` with `rsp_done`.
- R5: A write sends exactly three frames in this order: enable, write (address and data), disable.
- R6: An erase sends exactly three frames in this order: enable, erase (3+ADDR_W pulses), disable.
- R7: Between any two chip-select high intervals, and between the last one and `rsp_done`, chip-select stays low for at least `cfg_cs_gap` system cycles.
- R8: After a program frame and its gap, chip-select rises with the serial clock held low. Data-out is sampled once per half clock period, and the disable frame is not started until a 1 (ready) has been seen.
- R9: If `cfg_poll_max` consecutive polling samples read 0, polling is abandoned and the disable frame is still sent. `rsp_err` is then 1 with `rsp_done`.
- R10: `rsp_done` is high for exactly one cycle with chip-select low and `cmd_busy` low. A `cmd_start` presented in that cycle is accepted as a new command.
- R11: A `cmd_start` while `cmd_busy` is high is ignored: no extra frame and no extra `rsp_done`.
- R12: Operation code 3 (reserved) gives `rsp_done` with `rsp_err`=1 on the cycle after the strobe and causes no bus activity. The other codes are read 0, write 1 and erase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half_div | input | DIV_W | Serial clock half period minus one, in system cycles (at least 2) |
| cfg_cs_gap | input | GAP_W | Minimum chip-select low time, in system cycles |
| cfg_poll_max | input | TMO_W | Busy samples allowed before giving up |
| cmd_start | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 read, 1 write, 2 erase, 3 reserved |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to write |
| cmd_busy | output | 1 | Command in progress |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Error status, valid with `rsp_done` |
| rsp_rdata | output | DATA_W | Read result, valid with `rsp_done` after a read |
| ee_cs | output | 1 | Device chip-select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data toward the device |
| ee_do | input | 1 | Serial data and ready/busy from the device |

## Verification
Completion and command acceptance can fall in the same cycle: a new strobe may arrive in the very cycle `rsp_done` is high. The bench provokes this by reacting to a write's completion strobe with an immediate read of the same address. It judges the result from three things: the first strobe lasts one cycle, the read frame follows after the minimum chip-select gap, and the read returns the freshly written word. The bench's device model reports busy for a set number of cycles after each accepted program frame. The bench also checks that the disable frame never ends before that busy window closes, except in the timeout case, where the error flag is expected instead.

// File: rtl/uw_host_pkg.sv
// Shared types for the three-wire EEPROM host.
// Assumes: 2-bit wire opcodes and a 2-bit host operation code.
package uw_host_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } host_op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP, ST_POLL} seq_st_e;

    typedef enum logic [2:0] {PH_READ, PH_EWEN, PH_PROG, PH_POLL, PH_EWDS} seq_ph_e;

    localparam logic [1:0] WIRE_READ  = 2'b10;
    localparam logic [1:0] WIRE_WRITE = 2'b01;
    localparam logic [1:0] WIRE_ERASE = 2'b11;
    localparam logic [1:0] WIRE_CTRL  = 2'b00;
endpackage

// File: rtl/uw_sk_divider.sv
// Half-period tick generator for the serial clock.
// Produces a one-cycle tick every half_cyc+1 cycles while en is high;
// the count restarts from zero whenever en is low.
module uw_sk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_cyc,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count system cycles within one serial clock half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || cnt == half_cyc)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == half_cyc);
endmodule

// File: rtl/uw_frame_shifter.sv
// Serialises one left-aligned frame of len pulses onto the bus and
// shifts the device's data-out in on every falling serial clock.
// Assumes: load only while idle; tick comes from uw_sk_divider; din is
// already synchronised.
module uw_frame_shifter #(
    parameter int FRAME_W = 25,
    parameter int LEN_W   = 5,
    parameter int RX_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   len_in,
    input  logic               tick,
    input  logic               din,
    output logic               active,
    output logic               cs,
    output logic               sk,
    output logic               di,
    output logic               done,
    output logic [RX_W-1:0]    rx
);
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   npulse;

    // Frame state machine: load, raise clock, lower clock and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cs     <= 1'b0;
            sk     <= 1'b0;
            di     <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
            sh     <= '0;
            len_q  <= '0;
            npulse <= '0;
        end else begin
            done <= 1'b0;
            if (load && !active) begin
                active <= 1'b1;
                cs     <= 1'b1;
                sk     <= 1'b0;
                di     <= frame_in[FRAME_W-1];
                sh     <= frame_in << 1;
                len_q  <= len_in;
                npulse <= '0;
            end else if (active && tick) begin
                if (!sk) begin
                    sk <= 1'b1;
                end else begin
                    sk <= 1'b0;
                    rx <= {rx[RX_W-2:0], din};
                    sh <= sh << 1;
                    if (npulse == len_q - 1'b1) begin
                        active <= 1'b0;
                        cs     <= 1'b0;
                        di     <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        npulse <= npulse + 1'b1;
                        di     <= sh[FRAME_W-1];
                    end
                end
            end
        end
    end

    // R2
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sk && $past(sk)) |-> $stable(di));

    // R3
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sk);
endmodule

// File: rtl/uw_eeprom_host.sv
// Host engine for a three-wire serial EEPROM: read, write and erase.
// Program operations are bracketed by enable/disable frames and followed
// by ready/busy polling with a timeout.
// Assumes: cfg_half_div >= 2 so the two-flop data-out synchroniser settles
// within a half period; configuration is static while cmd_busy is high.
module uw_eeprom_host
    import uw_host_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int GAP_W  = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [GAP_W-1:0]  cfg_cs_gap,
    input  logic [TMO_W-1:0]  cfg_poll_max,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_busy,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam logic [LEN_W-1:0]  LONG_LEN  = LEN_W'(FRAME_W);
    localparam logic [LEN_W-1:0]  SHORT_LEN = LEN_W'(3 + ADDR_W);
    localparam logic [ADDR_W-1:0] EN_ADDR   = {2'b11, {(ADDR_W-2){1'b0}}};

    seq_st_e             st;
    seq_ph_e             ph;
    host_op_e            op_in;
    logic [ADDR_W-1:0]   a_q;
    logic [DATA_W-1:0]   d_q;
    logic                is_erase;
    logic                err_q;
    logic                ld;
    logic [FRAME_W-1:0]  fr;
    logic [LEN_W-1:0]    fl;
    logic [GAP_W-1:0]    gcnt;
    logic [TMO_W-1:0]    tcnt;
    logic                poll_cs;
    logic                do_m, do_s;
    logic                tick, sh_active, sh_cs, sh_done;
    logic [DATA_W-1:0]   sh_rx;
    logic                gap_end, tmo_end;

    function automatic logic [FRAME_W-1:0] mk_frame(input logic [1:0] code,
                                                    input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
        return {1'b1, code, a, d};
    endfunction

    assign op_in   = host_op_e'(cmd_op);
    assign gap_end = ({1'b0, gcnt} + 1'b1) >= {1'b0, cfg_cs_gap};
    assign tmo_end = ({1'b0, tcnt} + 1'b1) >= {1'b0, cfg_poll_max};

    // Two-flop synchroniser for the device's data-out line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            do_m <= 1'b0;
            do_s <= 1'b0;
        end else begin
            do_m <= ee_do;
            do_s <= do_m;
        end
    end

    uw_sk_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sh_active | poll_cs),
        .half_cyc (cfg_half_div),
        .tick     (tick)
    );

    uw_frame_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .RX_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .frame_in (fr),
        .len_in   (fl),
        .tick     (tick),
        .din      (do_s),
        .active   (sh_active),
        .cs       (sh_cs),
        .sk       (ee_sk),
        .di       (ee_di),
        .done     (sh_done),
        .rx       (sh_rx)
    );

    // Command sequencer: frame order, chip-select gaps, polling, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= PH_READ;
            a_q       <= '0;
            d_q       <= '0;
            is_erase  <= 1'b0;
            err_q     <= 1'b0;
            ld        <= 1'b0;
            fr        <= '0;
            fl        <= '0;
            gcnt      <= '0;
            tcnt      <= '0;
            poll_cs   <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            ld       <= 1'b0;
            rsp_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cmd_start) begin
                        a_q     <= cmd_addr;
                        d_q     <= cmd_wdata;
                        err_q   <= 1'b0;
                        rsp_err <= 1'b0;
                        case (op_in)
                            OP_READ: begin
                                fr <= mk_frame(WIRE_READ, cmd_addr, '0);
                                fl <= LONG_LEN;
                                ld <= 1'b1;
                                ph <= PH_READ;
                                st <= ST_FRAME;
                            end
                            OP_WRITE, OP_ERASE: begin
                                is_erase <= (op_in == OP_ERASE);
                                fr <= mk_frame(WIRE_CTRL, EN_ADDR, '0);
                                fl <= SHORT_LEN;
                                ld <= 1'b1;
                                ph <= PH_EWEN;
                                st <= ST_FRAME;
                            end
                            default: begin
                                rsp_done <= 1'b1;
                                rsp_err  <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_FRAME: begin
                    if (sh_done) begin
                        st   <= ST_GAP;
                        gcnt <= '0;
                        if (ph == PH_READ)
                            rsp_rdata <= sh_rx;
                    end
                end
                ST_GAP: begin
                    if (!gap_end) begin
                        gcnt <= gcnt + 1'b1;
                    end else begin
                        case (ph)
                            PH_EWEN: begin
                                fr <= is_erase ? mk_frame(WIRE_ERASE, a_q, '0)
                                               : mk_frame(WIRE_WRITE, a_q, d_q);
                                fl <= is_erase ? SHORT_LEN : LONG_LEN;
                                ld <= 1'b1;
                                ph <= PH_PROG;
                                st <= ST_FRAME;
                            end
                            PH_PROG: begin
                                poll_cs <= 1'b1;
                                tcnt    <= '0;
                                ph      <= PH_POLL;
                                st      <= ST_POLL;
                            end
                            PH_POLL: begin
                                fr <= mk_frame(WIRE_CTRL, '0, '0);
                                fl <= SHORT_LEN;
                                ld <= 1'b1;
                                ph <= PH_EWDS;
                                st <= ST_FRAME;
                            end
                            default: begin
                                st       <= ST_IDLE;
                                rsp_done <= 1'b1;
                                rsp_err  <= err_q;
                            end
                        endcase
                    end
                end
                ST_POLL: begin
                    if (tick) begin
                        if (do_s) begin
                            poll_cs <= 1'b0;
                            gcnt    <= '0;
                            st      <= ST_GAP;
                        end else if (tmo_end) begin
                            err_q   <= 1'b1;
                            poll_cs <= 1'b0;
                            gcnt    <= '0;
                            st      <= ST_GAP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cmd_busy = (st != ST_IDLE);
    assign ee_cs    = sh_cs | poll_cs;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10
    done_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!ee_cs && !cmd_busy));

    // R8
    poll_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cs |-> !ee_sk);
endmodule

// File: tb/uw_eeprom_host_bench.sv
module uw_eeprom_host_bench;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    cfg_div = 8'd2;
    logic [7:0]    cfg_gap = 8'd4;
    logic [15:0]   cfg_tmo = 16'd200;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_busy, rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          ee_cs, ee_sk, ee_di, ee_do;

    always #2 clk = ~clk;

    uw_eeprom_host u_uw_eeprom_host (
        .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_div), .cfg_cs_gap(cfg_gap),
        .cfg_poll_max(cfg_tmo), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int done_cnt = 0;

    // device model state
    logic [DW-1:0] mem [64];
    logic [DW-1:0] ref_mem [64];
    bit            wen = 0;
    int            busy_len = 150;
    int            busy_until = 0;
    int            ewds_cyc = 0;
    logic          rd_active = 0, rd_bit = 0;
    int            rd_idx = 15;
    logic [AW-1:0] rd_addr = '0;
    bit            started = 0;
    int            nbits = 0;
    logic [23:0]   word = '0;
    int            got_bits[$];
    logic [23:0]   got_word[$];
    int            exp_bits[$];
    logic [23:0]   exp_word[$];

    assign ee_do = rd_active ? rd_bit : ((cyc < busy_until) ? 1'b0 : 1'b1);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 16'(i * 16'h0101) ^ 16'hA5C3;
            ref_mem[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
        end
    end

    initial forever begin
        @(posedge clk);
        cyc = cyc + 1;
    end

    // Behavioural serial EEPROM device.
    initial forever begin
        @(posedge ee_sk or negedge ee_cs);
        if (!ee_cs) begin
            if (started && nbits > 0) begin
                got_bits.push_back(nbits);
                got_word.push_back(word);
                if (nbits == 8) begin
                    if (word[7:6] == 2'b00 && word[5:4] == 2'b11) wen = 1;
                    else if (word[7:6] == 2'b00 && word[5:0] == 6'd0) begin
                        wen = 0;
                        ewds_cyc = cyc;
                    end else if (word[7:6] == 2'b11 && wen) begin
                        mem[word[5:0]] = 16'hFFFF;
                        busy_until = cyc + busy_len;
                    end
                end else if (nbits == 24 && word[23:22] == 2'b01 && wen) begin
                    mem[word[21:16]] = word[15:0];
                    busy_until = cyc + busy_len;
                end
            end
            started = 0; nbits = 0; word = '0; rd_active = 0;
        end else if (!started) begin
            if (ee_di) begin started = 1; nbits = 0; word = '0; end
        end else begin
            word = {word[22:0], ee_di};
            nbits++;
            if (rd_active) begin
                rd_bit = mem[rd_addr][rd_idx];
                if (rd_idx == 0) begin rd_idx = 15; rd_addr = rd_addr + 1'b1; end
                else rd_idx--;
            end else if (nbits == 8 && word[7:6] == 2'b10) begin
                rd_active = 1; rd_bit = 0; rd_idx = 15; rd_addr = word[5:0];
            end
        end
    end

    // Per-cycle bus monitor.
    initial begin
        logic prev_sk, prev_di, prev_cs, prev_done;
        int hi_len, lo_len;
        prev_sk = 0; prev_di = 0; prev_cs = 0; prev_done = 0; hi_len = 0; lo_len = 1000;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (ee_sk) chk(ee_cs, "R3 sk high while cs low", ee_cs, 1);
                if (ee_sk && prev_sk) chk(ee_di == prev_di, "R2 di moved while sk high", ee_di, prev_di);
                if (ee_sk) hi_len++;
                if (prev_sk && !ee_sk) begin
                    chk(hi_len == cfg_div + 1, "R3 sk high length", hi_len, cfg_div + 1);
                    hi_len = 0;
                end
                if (!ee_cs) lo_len++;
                if (ee_cs && !prev_cs) begin
                    chk(lo_len >= cfg_gap, "R7 cs low gap", lo_len, cfg_gap);
                    lo_len = 0;
                end
                if (rsp_done) begin
                    done_cnt++;
                    chk(!ee_cs && !cmd_busy, "R10 done with bus idle", {ee_cs, cmd_busy}, 0);
                    chk(lo_len >= cfg_gap, "R7 gap before done", lo_len, cfg_gap);
                    chk(!prev_done, "R10 done longer than one cycle", prev_done, 0);
                end
            end
            prev_sk = ee_sk; prev_di = ee_di; prev_cs = ee_cs; prev_done = rsp_done;
        end
    end

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic push_exp(input int b, input logic [23:0] w);
        exp_bits.push_back(b);
        exp_word.push_back(w);
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_start = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!rsp_done && n < 20000) begin @(negedge clk); n++; end
        chk(rsp_done, tag, rsp_done, 1);
    endtask

    task automatic expect_frames(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_bits.delete(); exp_word.delete();
        case (op)
            2'd0: push_exp(24, {2'b10, a, 16'h0});
            2'd1: begin push_exp(8, 24'h30); push_exp(24, {2'b01, a, d}); push_exp(8, 24'h0); end
            2'd2: begin push_exp(8, 24'h30); push_exp(8, {16'h0, 2'b11, a}); push_exp(8, 24'h0); end
            default: ;
        endcase
    endtask

    task automatic cmp_frames(input string tag);
        chk(got_bits.size() == exp_bits.size(), {tag, " frame count"}, got_bits.size(), exp_bits.size());
        for (int i = 0; i < exp_bits.size() && i < got_bits.size(); i++) begin
            chk(got_bits[i] == exp_bits[i], {tag, " frame length"}, got_bits[i], exp_bits[i]);
            chk(got_word[i] == exp_word[i], {tag, " frame bits"}, got_word[i], exp_word[i]);
        end
        got_bits.delete(); got_word.delete();
    endtask

    task automatic after_done(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input bit exp_err, input string tag);
        chk(rsp_err == exp_err, {tag, " error flag"}, rsp_err, exp_err);
        if (op == 2'd0)
            chk(rsp_rdata == ref_mem[a], "R4 read data", rsp_rdata, ref_mem[a]);
        if ((op == 2'd1 || op == 2'd2) && !exp_err) begin
            ref_mem[a] = (op == 2'd1) ? d : 16'hFFFF;
            chk(mem[a] == ref_mem[a], {tag, " stored word"}, mem[a], ref_mem[a]);
            chk(ewds_cyc >= busy_until, "R8 disable only after ready", ewds_cyc, busy_until);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit exp_err, input string tag);
        got_bits.delete(); got_word.delete();
        expect_frames(op, a, d);
        @(negedge clk);
        issue(op, a, d);
        wait_done({tag, " done seen"});
        after_done(op, a, d, exp_err, tag);
        cmp_frames(tag);
    endtask

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        // R1: outputs idle during and right after reset
        chk({ee_cs, ee_sk, ee_di, cmd_busy, rsp_done, rsp_err} == 6'b0, "R1 reset outputs",
            {ee_cs, ee_sk, ee_di, cmd_busy, rsp_done, rsp_err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, cmd_busy, rsp_done, rsp_err} == 6'b0, "R1 after reset",
            {ee_cs, ee_sk, ee_di, cmd_busy, rsp_done, rsp_err}, 0);

        do_cmd(2'd0, 6'd5, '0, 0, "R4 R2 read");
        do_cmd(2'd1, 6'd5, 16'h1234, 0, "R5 write");
        do_cmd(2'd0, 6'd5, '0, 0, "R4 read back");
        do_cmd(2'd2, 6'd63, '0, 0, "R6 erase");
        do_cmd(2'd0, 6'd63, '0, 0, "R4 read erased");
        do_cmd(2'd3, 6'd1, '0, 1, "R12 reserved op");

        // R10: new strobe accepted in the completion cycle
        got_bits.delete(); got_word.delete();
        expect_frames(2'd1, 6'd9, 16'hBEEF);
        @(negedge clk);
        issue(2'd1, 6'd9, 16'hBEEF);
        wait_done("R10 first done");
        after_done(2'd1, 6'd9, 16'hBEEF, 0, "R10 write");
        issue(2'd0, 6'd9, '0);
        cmp_frames("R10 write");
        expect_frames(2'd0, 6'd9, '0);
        chk(cmd_busy, "R10 strobe in done cycle accepted", cmd_busy, 1);
        wait_done("R10 second done");
        after_done(2'd0, 6'd9, '0, 0, "R10 read");
        cmp_frames("R10 read");

        // R11: strobe during a write is ignored
        got_bits.delete(); got_word.delete();
        expect_frames(2'd1, 6'd20, 16'h0F0F);
        @(negedge clk);
        issue(2'd1, 6'd20, 16'h0F0F);
        repeat (30) @(negedge clk);
        issue(2'd0, 6'd3, '0);
        d0 = done_cnt;
        wait_done("R11 done");
        after_done(2'd1, 6'd20, 16'h0F0F, 0, "R11 write");
        repeat (40) @(negedge clk);
        chk(!cmd_busy && !ee_cs, "R11 no extra activity", {cmd_busy, ee_cs}, 0);
        chk(done_cnt == d0 + 1, "R11 single done", done_cnt, d0 + 1);
        cmp_frames("R11 write");

        // R3 with a slower divider
        cfg_div = 8'd5;
        do_cmd(2'd1, 6'd33, 16'h8001, 0, "R5 R3 slow write");
        do_cmd(2'd0, 6'd33, '0, 0, "R4 R3 slow read");
        cfg_div = 8'd2;

        // R9: busy outlasts the polling budget
        cfg_tmo = 16'd10;
        busy_len = 3000;
        do_cmd(2'd1, 6'd40, 16'h5555, 1, "R9 timeout");
        ref_mem[40] = 16'h5555;
        while (cyc < busy_until + 10) @(negedge clk);
        cfg_tmo = 16'd200;
        busy_len = 150;
        do_cmd(2'd0, 6'd40, '0, 0, "R4 read after timeout");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule